// File: doc/BRIEF.md
# External Memory Select and I/O Wait-State Generator

This block sits between a processor's external bus sequencer and the pins that enable external memories and peripherals. Each bus request arrives tagged with one of four address spaces (program, data, boot or I/O). The block drives one active-low enable strobe per space. It also drives a composite enable that goes low whenever the strobe of any space in a programmable set is low. A single memory device can then answer in more than one space.

For I/O requests, only the low 11 address bits are decoded. They select one of four 512-location regions. Each region has its own 3-bit wait count, and the block holds the access open for that many extra cycles. It pulls its ready output low during those cycles, and the requester waits until ready returns high. Two configuration write ports load the composite-enable set and the four region wait counts.

Top module: `extsel_gen`

## Requirements
- R1: After reset all four space strobes `sel_n` and `csel_n` are high and `ready` is high.
- R2: A request is accepted on a rising edge where `req_valid` and `ready` are both high. From the next cycle, exactly one strobe is low, chosen by `req_space`: 0 program → `sel_n[0]`, 1 data → `sel_n[1]`, 2 boot → `sel_n[2]`, 3 I/O → `sel_n[3]`.
- R3: Program, data and boot accesses hold their strobe low for exactly one cycle, and `ready` stays high throughout.
- R4: For I/O requests the region is `req_addr[10:9]` (0x000–0x1FF region 0, up to 0x600–0x7FF region 3). `req_addr[13:11]` has no effect on the region.
- R5: An I/O access whose region holds wait value N keeps `sel_n[3]` low for N+1 cycles. `ready` is low for the first N of them and high in the last.
- R6: A request presented while `ready` is low is ignored: no strobe it would select goes low because of it.
- R7: `csel_n` is low exactly during an access whose space has its enable bit set, where bit k of the enable set belongs to space k. A write to `cfg_csel_wdata` applies to accesses that start after the write.
- R8: At reset the enable set is 4'b1011 (boot excluded) and every region wait value is 7.
- R9: A wait-register write on the same edge that accepts an I/O request does not affect that request. It applies to later requests.
- R10: A request held during the last cycle of an I/O access is accepted on that edge. Its strobe follows with no idle cycle between the two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_space | input | 2 | Space of request (0 prog, 1 data, 2 boot, 3 I/O) |
| req_addr | input | 14 | Request address |
| cfg_csel_we | input | 1 | Write strobe for composite enable set |
| cfg_csel_wdata | input | 4 | New composite enable set, bit per space |
| cfg_wait_we | input | 1 | Write strobe for a region wait register |
| cfg_wait_idx | input | 2 | Region index written |
| cfg_wait_wdata | input | 3 | New wait value 0..7 |
| sel_n | output | 4 | Per-space active-low strobes |
| csel_n | output | 1 | Composite active-low strobe |
| ready | output | 1 | High when the bus may complete/accept |

## Verification
The properties assume that `req_space` is a defined two-bit value whenever `req_valid` is high, and that the requester obeys `ready`. Requests presented while `ready` is low are tolerated, but the properties expect them to be dropped. The stimulus changes inputs only on falling clock edges. It drives requests for exactly the cycles it intends, and pulses configuration writes for single cycles. One test deliberately offers a request while `ready` is low to confirm it is dropped.

// File: rtl/extsel_pkg.sv
package extsel_pkg;
    localparam int SPACE_N = 4;

    typedef enum logic [1:0] {
        SP_PROG = 2'd0,
        SP_DATA = 2'd1,
        SP_BOOT = 2'd2,
        SP_IO   = 2'd3
    } space_e;

    // composite enable at reset: every space but boot
    localparam logic [SPACE_N-1:0] CSEL_EN_RESET = 4'b1011;
endpackage

// File: rtl/extsel_cfg_regs.sv
module extsel_cfg_regs #(
    parameter int REGION_N = 4,
    parameter int WAIT_W   = 3,
    parameter int SPACE_N  = 4,
    parameter int IDX_W    = $clog2(REGION_N),
    parameter logic [SPACE_N-1:0] EN_RESET = '1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       csel_we,
    input  logic [SPACE_N-1:0]         csel_wdata,
    input  logic                       wait_we,
    input  logic [IDX_W-1:0]           wait_idx,
    input  logic [WAIT_W-1:0]          wait_wdata,
    output logic [SPACE_N-1:0]         csel_en,
    output logic [REGION_N*WAIT_W-1:0] wait_flat
);
    logic [SPACE_N-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (csel_we) en_d = csel_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= EN_RESET;
        else        en_q <= en_d;
    end

    assign csel_en = en_q;

    for (genvar g = 0; g < REGION_N; g++) begin : g_wait
        logic [WAIT_W-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (wait_we && (wait_idx == IDX_W'(g))) w_d = wait_wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) w_q <= '1;
            else        w_q <= w_d;
        end

        assign wait_flat[g*WAIT_W +: WAIT_W] = w_q;
    end
endmodule

// File: rtl/extsel_region_mux.sv
module extsel_region_mux #(
    parameter int REGION_N  = 4,
    parameter int WAIT_W    = 3,
    parameter int IO_ADDR_W = 11,
    parameter int IDX_W     = $clog2(REGION_N)
) (
    input  logic [IO_ADDR_W-1:0]       io_addr,
    input  logic [REGION_N*WAIT_W-1:0] wait_flat,
    output logic [WAIT_W-1:0]          wait_sel
);
    logic [IDX_W-1:0] region;

    // equal-sized regions: the top bits of the port address pick the region
    assign region   = io_addr[IO_ADDR_W-1 -: IDX_W];
    assign wait_sel = wait_flat[region*WAIT_W +: WAIT_W];
endmodule

// File: rtl/extsel_csel_merge.sv
module extsel_csel_merge #(
    parameter int SPACE_N = 4
) (
    input  logic [SPACE_N-1:0] sel_hot,
    input  logic [SPACE_N-1:0] en,
    output logic               hit
);
    assign hit = |(sel_hot & en);
endmodule

// File: rtl/extsel_gen.sv
module extsel_gen
    import extsel_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int IO_ADDR_W = 11,
    parameter int REGION_N  = 4,
    parameter int WAIT_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [1:0]                    req_space,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic                          cfg_csel_we,
    input  logic [SPACE_N-1:0]            cfg_csel_wdata,
    input  logic                          cfg_wait_we,
    input  logic [$clog2(REGION_N)-1:0]   cfg_wait_idx,
    input  logic [WAIT_W-1:0]             cfg_wait_wdata,
    output logic [SPACE_N-1:0]            sel_n,
    output logic                          csel_n,
    output logic                          ready
);
    localparam int IDX_W = $clog2(REGION_N);

    typedef struct packed {
        logic               busy;
        logic [SPACE_N-1:0] sel;
        logic               csel;
        logic [WAIT_W-1:0]  cnt;
    } state_t;

    state_t st_d, st_q;

    logic [SPACE_N-1:0]         csel_en;
    logic [REGION_N*WAIT_W-1:0] wait_flat;
    logic [WAIT_W-1:0]          wait_sel;
    logic [SPACE_N-1:0]         req_hot;
    logic                       csel_hit;
    logic                       accept;
    logic                       unused_addr_hi;
    space_e                     space;

    assign unused_addr_hi = ^req_addr[ADDR_W-1:IO_ADDR_W];
    assign space          = space_e'(req_space);
    assign req_hot        = SPACE_N'(1) << req_space;

    extsel_cfg_regs #(
        .REGION_N (REGION_N),
        .WAIT_W   (WAIT_W),
        .SPACE_N  (SPACE_N),
        .IDX_W    (IDX_W),
        .EN_RESET (CSEL_EN_RESET)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .csel_we    (cfg_csel_we),
        .csel_wdata (cfg_csel_wdata),
        .wait_we    (cfg_wait_we),
        .wait_idx   (cfg_wait_idx),
        .wait_wdata (cfg_wait_wdata),
        .csel_en    (csel_en),
        .wait_flat  (wait_flat)
    );

    extsel_region_mux #(
        .REGION_N  (REGION_N),
        .WAIT_W    (WAIT_W),
        .IO_ADDR_W (IO_ADDR_W),
        .IDX_W     (IDX_W)
    ) u_region (
        .io_addr   (req_addr[IO_ADDR_W-1:0]),
        .wait_flat (wait_flat),
        .wait_sel  (wait_sel)
    );

    extsel_csel_merge #(
        .SPACE_N (SPACE_N)
    ) u_merge (
        .sel_hot (req_hot),
        .en      (csel_en),
        .hit     (csel_hit)
    );

    // wait cycles remain while the counter is non-zero
    assign ready  = (st_q.cnt == '0);
    assign accept = req_valid && ready;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (accept) begin
            st_d.busy = 1'b1;
            st_d.sel  = req_hot;
            st_d.csel = csel_hit;
            st_d.cnt  = (space == SP_IO) ? wait_sel : '0;
        end else begin
            st_d.busy = 1'b0;
            st_d.sel  = '0;
            st_d.csel = 1'b0;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_n  = ~(st_q.sel & {SPACE_N{st_q.busy}});
    assign csel_n = ~(st_q.csel & st_q.busy);
endmodule

// File: rtl/extsel_checker.sv
module extsel_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_space,
    input logic [3:0] sel_n,
    input logic       csel_n,
    input logic       ready
);
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> (sel_n == ~(4'b0001 << $past(req_space))));

    p_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n[2:0] != 3'b111) |-> ready);

    p_io_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !sel_n[3]);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(sel_n) && $stable(csel_n)));

    p_csel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !csel_n |-> (sel_n != 4'hF));
endmodule

bind extsel_gen extsel_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_space (req_space),
    .sel_n     (sel_n),
    .csel_n    (csel_n),
    .ready     (ready)
);

// File: tb/extsel_gen_tb.sv
module extsel_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_space = 2'd0;
    logic [13:0] req_addr = '0;
    logic       cfg_csel_we = 1'b0;
    logic [3:0] cfg_csel_wdata = '0;
    logic       cfg_wait_we = 1'b0;
    logic [1:0] cfg_wait_idx = '0;
    logic [2:0] cfg_wait_wdata = '0;
    logic [3:0] sel_n;
    logic       csel_n;
    logic       ready;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    extsel_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
        .req_addr(req_addr), .cfg_csel_we(cfg_csel_we), .cfg_csel_wdata(cfg_csel_wdata),
        .cfg_wait_we(cfg_wait_we), .cfg_wait_idx(cfg_wait_idx),
        .cfg_wait_wdata(cfg_wait_wdata), .sel_n(sel_n), .csel_n(csel_n), .ready(ready)
    );

    // {space[1:0], addr[13:0], strobe length[3:0], composite expected low}
    localparam int NV = 8;
    localparam logic [20:0] VEC [NV] = '{
        {2'd0, 14'h0123, 4'd1, 1'b1},
        {2'd1, 14'h2abc, 4'd1, 1'b1},
        {2'd2, 14'h0010, 4'd1, 1'b0},
        {2'd3, 14'h0005, 4'd3, 1'b1},
        {2'd3, 14'h3a05, 4'd1, 1'b1},
        {2'd3, 14'h0400, 4'd7, 1'b1},
        {2'd3, 14'h07ff, 4'd5, 1'b1},
        {2'd3, 14'h1dff, 4'd7, 1'b1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_wait(input logic [1:0] idx, input logic [2:0] val);
        cfg_wait_we = 1'b1; cfg_wait_idx = idx; cfg_wait_wdata = val;
        @(negedge clk);
        cfg_wait_we = 1'b0;
    endtask

    task automatic wr_csel(input logic [3:0] val);
        cfg_csel_we = 1'b1; cfg_csel_wdata = val;
        @(negedge clk);
        cfg_csel_we = 1'b0;
    endtask

    // called at a falling edge; returns after the strobe has gone high again
    task automatic access(input logic [1:0] sp, input logic [13:0] ad,
                          input int elen, input bit ecs, input string tag);
        int n = 0;
        int rl = 0;
        int cs_low = 0;
        req_valid = 1'b1; req_space = sp; req_addr = ad;
        @(negedge clk);
        req_valid = 1'b0; cfg_wait_we = 1'b0; cfg_csel_we = 1'b0;
        while (!sel_n[sp] && n < 20) begin
            n++;
            if (!ready) rl++;
            if (!csel_n) cs_low++;
            @(negedge clk);
        end
        check(n == elen, {tag, " strobe length"}, n, elen);
        check(rl == elen - 1, {tag, " ready-low cycles"}, rl, elen - 1);
        check(cs_low == (ecs ? elen : 0), {tag, " composite cycles"}, cs_low, ecs ? elen : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle outputs after reset
        check(sel_n == 4'hF, "R1 sel_n idle", sel_n, 15);
        check(csel_n == 1'b1, "R1 csel_n idle", csel_n, 1);
        check(ready == 1'b1, "R1 ready idle", ready, 1);

        // R8 reset wait value 7 and reset enable set 1011
        access(2'd3, 14'h0000, 8, 1'b1, "R8 io default wait");
        access(2'd2, 14'h0000, 1, 1'b0, "R8 boot excluded");
        access(2'd1, 14'h0000, 1, 1'b1, "R8 data included");

        wr_wait(2'd0, 3'd2);
        wr_wait(2'd1, 3'd0);
        wr_wait(2'd2, 3'd6);
        wr_wait(2'd3, 3'd4);

        // R2 R3 R4 R5 vector table
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][20:19], VEC[i][18:5], int'(VEC[i][4:1]), VEC[i][0],
                   $sformatf("R2/R3/R4/R5 vec%0d", i));
        end

        // R9 write on the accepting edge uses the old value (2), later ones the new (5)
        cfg_wait_we = 1'b1; cfg_wait_idx = 2'd0; cfg_wait_wdata = 3'd5;
        access(2'd3, 14'h0044, 3, 1'b1, "R9 same-edge write");
        access(2'd3, 14'h0044, 6, 1'b1, "R9 later request");

        // R6 program request offered while ready is low is dropped
        begin
            int seen = 0;
            req_valid = 1'b1; req_space = 2'd3; req_addr = 14'h0600;
            @(negedge clk);
            req_space = 2'd0;
            @(negedge clk);
            req_valid = 1'b0;
            for (int k = 0; k < 12; k++) begin
                if (!sel_n[0]) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R6 request during wait ignored", seen, 0);
        end

        // R10 held request accepted in final I/O cycle, no gap
        begin
            int n = 0;
            req_valid = 1'b1; req_space = 2'd3; req_addr = 14'h0000;
            @(negedge clk);
            req_space = 2'd0;
            while (!sel_n[3] && n < 20) begin n++; @(negedge clk); end
            req_valid = 1'b0;
            check(!sel_n[0], "R10 back-to-back strobe", sel_n[0], 0);
            check(n == 6, "R10 io length before handoff", n, 6);
            @(negedge clk);
            check(sel_n == 4'hF, "R10 single program cycle", sel_n, 15);
        end

        // R7 reprogram the composite set to boot only
        wr_csel(4'b0100);
        access(2'd2, 14'h0000, 1, 1'b1, "R7 boot now included");
        access(2'd0, 14'h0000, 1, 1'b0, "R7 program now excluded");
        access(2'd3, 14'h0200, 1, 1'b0, "R7 io now excluded");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule